// File: doc/BRIEF.md
# Control Register Intercept Unit

This unit sits next to a small CPU core and owns three virtualized control registers: two guarded registers (CR0 and CR4) and the page-table base register (CR3). Every guest access to one of them goes through the unit. The unit decides whether the access completes locally or is handed to the monitor as a virtual-machine exit.

For CR0 and CR4, a per-bit ownership mask splits the register into host-owned and guest-owned bits, and a per-register read shadow supplies what the guest sees in the host-owned bits. Guest reads never leave the guest. A guest write exits only when it would alter a host-owned bit relative to the shadow. A CR3 load avoids the exit when its value matches one of the currently enabled entries of a small list of approved page-table bases.

A separate host configuration port loads the masks, the shadows, the approved CR3 values and the count of enabled entries. The unit keeps the three live register values itself and presents them to the core. On an exit it emits a one-cycle pulse carrying the register identity and the value the guest tried to write.

Top module: `crv_intercept`

## Requirements
- R1: After reset, CR0 holds 0x11, CR4 and CR3 hold 0, all masks, shadows, approved values and the enabled count are 0, and no exit is signalled.
- R2: A guest read of CR0 (select 00) or CR4 (select 01) returns (live AND NOT mask) OR (shadow AND mask) combinationally in the request cycle, and never causes an exit.
- R3: A guest read of CR3 (select 10) returns the live CR3 value in the request cycle without an exit.
- R4: A guest write to CR0 or CR4 for which ((data XOR shadow) AND mask) is zero loads the data into the live register at the next clock edge, without an exit. The comparison uses the shadow, not the live value.
- R5: A guest write to CR0 or CR4 for which ((data XOR shadow) AND mask) is nonzero leaves the live register unchanged and raises an exit.
- R6: An exit is a pulse of exit_valid lasting one cycle per offending request, visible in the cycle after the request. It carries reason 00 (CR0), 01 (CR4) or 10 (CR3) and, as qualification, the attempted write value.
- R7: A CR3 write whose value equals an approved entry with index below the enabled count loads CR3 at the next edge without an exit. A count above the list size enables every entry.
- R8: A CR3 write that matches no enabled entry raises an exit and leaves CR3 unchanged. With a count of 0, every CR3 write exits.
- R9: Host configuration writes use these addresses: 0 CR0 mask, 1 CR0 shadow, 2 CR4 mask, 3 CR4 shadow, 4 enabled count (low 3 bits), 8 to 11 approved CR3 entries 0 to 3. A write takes effect from the next cycle, so a guest request in the same cycle still sees the old setting.
- R10: A guest request with select 11 has no effect: no exit, no register change, and read data 0.
- R11: A bit marked host-owned with shadow 0 always reads 0, whatever the live register holds in that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Guest access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_sel | input | 2 | Register select: 00 CR0, 01 CR4, 10 CR3, 11 none |
| req_wdata | input | 64 | Guest write value |
| rd_data | output | 64 | Guest read value, combinational |
| cfg_we | input | 1 | Host configuration write strobe |
| cfg_addr | input | 4 | Host configuration address |
| cfg_wdata | input | 64 | Host configuration data |
| cr0_o | output | 64 | Live CR0 value |
| cr4_o | output | 64 | Live CR4 value |
| cr3_o | output | 64 | Live CR3 value |
| exit_valid | output | 1 | Exit pulse |
| exit_reason | output | 2 | Register that caused the exit |
| exit_qual | output | 64 | Attempted write value of the exit |

## Verification
The bench targets a write whose host-owned bits match the shadow but differ from the live value, and the opposite case. A design that compared against the live register would exit on the first and load on the second. It also places a mask update and a guest write in the same cycle; a design that applied configuration early would exit where the old mask allows the write. For CR3 it tries a value held in an entry above the enabled count, and counts of 0 and 7. An off-by-one or unguarded index check would approve the disabled entry, and a narrow count compare would reject the overflowed count. It also uses reserved high CR4 bits, back-to-back exits and the unused select, which catch a merge that leaks live bits, a pulse that sticks high and a decode that treats select 11 as a register.

// File: rtl/crv_pkg.sv
package crv_pkg;

  typedef enum logic [1:0] {
    CRS_CR0  = 2'b00,
    CRS_CR4  = 2'b01,
    CRS_CR3  = 2'b10,
    CRS_NONE = 2'b11
  } cr_sel_e;

  localparam int CFG_AW = 4;

  localparam logic [CFG_AW-1:0] CFG_MASK0    = 4'd0;
  localparam logic [CFG_AW-1:0] CFG_SHAD0    = 4'd1;
  localparam logic [CFG_AW-1:0] CFG_MASK4    = 4'd2;
  localparam logic [CFG_AW-1:0] CFG_SHAD4    = 4'd3;
  localparam logic [CFG_AW-1:0] CFG_TCNT     = 4'd4;
  localparam int                CFG_TGT_BASE = 8;

endpackage

// File: rtl/crv_rst_sync.sv
module crv_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_ns
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];

endmodule

// File: rtl/crv_host_cfg.sv
module crv_host_cfg
  import crv_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NTGT  = 4,
  parameter int CNT_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [CFG_AW-1:0]          cfg_addr,
  input  logic [XLEN-1:0]            cfg_wdata,
  output logic [XLEN-1:0]            mask0_o,
  output logic [XLEN-1:0]            shad0_o,
  output logic [XLEN-1:0]            mask4_o,
  output logic [XLEN-1:0]            shad4_o,
  output logic [CNT_W-1:0]           tcnt_o,
  output logic [NTGT-1:0][XLEN-1:0]  tgt_o
);

  logic            en_mask0, en_shad0, en_mask4, en_shad4, en_tcnt;
  logic [NTGT-1:0] en_tgt;

  logic [XLEN-1:0]           mask0_q, shad0_q, mask4_q, shad4_q;
  logic [CNT_W-1:0]          tcnt_q;
  logic [NTGT-1:0][XLEN-1:0] tgt_q;

  // write-enable decode
  always_comb begin
    en_mask0 = cfg_we && (cfg_addr == CFG_MASK0);
    en_shad0 = cfg_we && (cfg_addr == CFG_SHAD0);
    en_mask4 = cfg_we && (cfg_addr == CFG_MASK4);
    en_shad4 = cfg_we && (cfg_addr == CFG_SHAD4);
    en_tcnt  = cfg_we && (cfg_addr == CFG_TCNT);
  end

  for (genvar i = 0; i < NTGT; i++) begin : g_tgt_en
    localparam logic [CFG_AW-1:0] TADDR = CFG_AW'(CFG_TGT_BASE + i);
    assign en_tgt[i] = cfg_we && (cfg_addr == TADDR);
  end

  // storage with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask0_q <= '0;
      shad0_q <= '0;
      mask4_q <= '0;
      shad4_q <= '0;
      tcnt_q  <= '0;
    end else begin
      if (en_mask0) mask0_q <= cfg_wdata;
      if (en_shad0) shad0_q <= cfg_wdata;
      if (en_mask4) mask4_q <= cfg_wdata;
      if (en_shad4) shad4_q <= cfg_wdata;
      if (en_tcnt)  tcnt_q  <= cfg_wdata[CNT_W-1:0];
    end
  end

  for (genvar i = 0; i < NTGT; i++) begin : g_tgt_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tgt_q[i] <= '0;
      else if (en_tgt[i]) tgt_q[i] <= cfg_wdata;
    end
  end

  assign mask0_o = mask0_q;
  assign shad0_o = shad0_q;
  assign mask4_o = mask4_q;
  assign shad4_o = shad4_q;
  assign tcnt_o  = tcnt_q;
  assign tgt_o   = tgt_q;

endmodule

// File: rtl/crv_owned_reg.sv
module crv_owned_reg #(
  parameter int              XLEN    = 64,
  parameter logic [XLEN-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hit,
  input  logic [XLEN-1:0] wdata,
  input  logic [XLEN-1:0] mask,
  input  logic [XLEN-1:0] shadow,
  output logic [XLEN-1:0] live_o,
  output logic [XLEN-1:0] view_o,
  output logic            host_change_o
);

  logic [XLEN-1:0] live_q;
  logic [XLEN-1:0] live_d;
  logic            host_change;
  logic            load;

  // host-owned bits are judged against the shadow image
  always_comb begin
    host_change = |((wdata ^ shadow) & mask);
    load        = wr_hit && !host_change;
    live_d      = load ? wdata : live_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    live_q <= RST_VAL;
    else if (load) live_q <= live_d;
  end

  assign view_o        = (live_q & ~mask) | (shadow & mask);
  assign live_o        = live_q;
  assign host_change_o = host_change;

endmodule

// File: rtl/crv_cr3_filter.sv
module crv_cr3_filter #(
  parameter int XLEN  = 64,
  parameter int NTGT  = 4,
  parameter int CNT_W = 3
) (
  input  logic [XLEN-1:0]           cand,
  input  logic [CNT_W-1:0]          tcnt,
  input  logic [NTGT-1:0][XLEN-1:0] tgt,
  output logic                      hit_o
);

  localparam int IW = CNT_W + 1;

  logic [NTGT-1:0] ent_en;
  logic [NTGT-1:0] ent_hit;

  for (genvar i = 0; i < NTGT; i++) begin : g_ent
    localparam logic [IW-1:0] IDX = IW'(i);
    assign ent_en[i]  = ({1'b0, tcnt} > IDX);
    assign ent_hit[i] = ent_en[i] && (tgt[i] == cand);
  end

  assign hit_o = |ent_hit;

endmodule

// File: rtl/crv_intercept.sv
module crv_intercept
  import crv_pkg::*;
#(
  parameter int              XLEN    = 64,
  parameter int              NTGT    = 4,
  parameter int              CNT_W   = 3,
  parameter logic [XLEN-1:0] CR0_RST = 64'h11,
  parameter logic [XLEN-1:0] CR4_RST = '0,
  parameter logic [XLEN-1:0] CR3_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_sel,
  input  logic [XLEN-1:0]   req_wdata,
  output logic [XLEN-1:0]   rd_data,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [XLEN-1:0]   cfg_wdata,
  output logic [XLEN-1:0]   cr0_o,
  output logic [XLEN-1:0]   cr4_o,
  output logic [XLEN-1:0]   cr3_o,
  output logic              exit_valid,
  output logic [1:0]        exit_reason,
  output logic [XLEN-1:0]   exit_qual
);

  logic rst_ns;

  crv_rst_sync i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_ns (rst_ns)
  );

  // configuration storage
  logic [XLEN-1:0]           mask_cr0, shadow_cr0, mask_cr4, shadow_cr4;
  logic [CNT_W-1:0]          tgt_cnt;
  logic [NTGT-1:0][XLEN-1:0] tgt_list;

  crv_host_cfg #(.XLEN(XLEN), .NTGT(NTGT), .CNT_W(CNT_W)) i_cfg (
    .clk       (clk),
    .rst_n     (rst_ns),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .mask0_o   (mask_cr0),
    .shad0_o   (shadow_cr0),
    .mask4_o   (mask_cr4),
    .shad4_o   (shadow_cr4),
    .tcnt_o    (tgt_cnt),
    .tgt_o     (tgt_list)
  );

  // request decode
  cr_sel_e sel;
  logic    guest_wr, wr_cr0, wr_cr4, wr_cr3;

  always_comb begin
    sel      = cr_sel_e'(req_sel);
    guest_wr = req_valid && req_write;
    wr_cr0   = guest_wr && (sel == CRS_CR0);
    wr_cr4   = guest_wr && (sel == CRS_CR4);
    wr_cr3   = guest_wr && (sel == CRS_CR3);
  end

  // guarded registers
  logic [XLEN-1:0] live_cr0, view_cr0, live_cr4, view_cr4;
  logic            chg_cr0, chg_cr4;

  crv_owned_reg #(.XLEN(XLEN), .RST_VAL(CR0_RST)) i_cr0 (
    .clk           (clk),
    .rst_n         (rst_ns),
    .wr_hit        (wr_cr0),
    .wdata         (req_wdata),
    .mask          (mask_cr0),
    .shadow        (shadow_cr0),
    .live_o        (live_cr0),
    .view_o        (view_cr0),
    .host_change_o (chg_cr0)
  );

  crv_owned_reg #(.XLEN(XLEN), .RST_VAL(CR4_RST)) i_cr4 (
    .clk           (clk),
    .rst_n         (rst_ns),
    .wr_hit        (wr_cr4),
    .wdata         (req_wdata),
    .mask          (mask_cr4),
    .shadow        (shadow_cr4),
    .live_o        (live_cr4),
    .view_o        (view_cr4),
    .host_change_o (chg_cr4)
  );

  // page-table base with approved-value filter
  logic            cr3_hit, cr3_load;
  logic [XLEN-1:0] cr3_q, cr3_d;

  crv_cr3_filter #(.XLEN(XLEN), .NTGT(NTGT), .CNT_W(CNT_W)) i_cr3_filt (
    .cand  (req_wdata),
    .tcnt  (tgt_cnt),
    .tgt   (tgt_list),
    .hit_o (cr3_hit)
  );

  always_comb begin
    cr3_load = wr_cr3 && cr3_hit;
    cr3_d    = cr3_load ? req_wdata : cr3_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)       cr3_q <= CR3_RST;
    else if (cr3_load) cr3_q <= cr3_d;
  end

  // exit generation
  logic            exit_d;
  logic            exit_q;
  logic [1:0]      reason_q;
  logic [XLEN-1:0] qual_q;

  always_comb begin
    exit_d = (wr_cr0 && chg_cr0) ||
             (wr_cr4 && chg_cr4) ||
             (wr_cr3 && !cr3_hit);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) exit_q <= 1'b0;
    else         exit_q <= exit_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      reason_q <= '0;
      qual_q   <= '0;
    end else if (exit_d) begin
      reason_q <= req_sel;
      qual_q   <= req_wdata;
    end
  end

  // guest read path
  always_comb begin
    unique case (sel)
      CRS_CR0: rd_data = view_cr0;
      CRS_CR4: rd_data = view_cr4;
      CRS_CR3: rd_data = cr3_q;
      default: rd_data = '0;
    endcase
  end

  assign cr0_o       = live_cr0;
  assign cr4_o       = live_cr4;
  assign cr3_o       = cr3_q;
  assign exit_valid  = exit_q;
  assign exit_reason = reason_q;
  assign exit_qual   = qual_q;

endmodule

// File: rtl/crv_intercept_chk.sv
module crv_intercept_chk #(
  parameter int XLEN  = 64,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [1:0]       req_sel,
  input logic [XLEN-1:0]  req_wdata,
  input logic [XLEN-1:0]  rd_data,
  input logic [XLEN-1:0]  mask0,
  input logic [XLEN-1:0]  shad0,
  input logic [CNT_W-1:0] tcnt,
  input logic [XLEN-1:0]  cr0_o,
  input logic [XLEN-1:0]  cr4_o,
  input logic [XLEN-1:0]  cr3_o,
  input logic             exit_valid,
  input logic [1:0]       exit_reason,
  input logic [XLEN-1:0]  exit_qual
);

  assert_read_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> !exit_valid);

  assert_read_merge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_sel == 2'b00) |->
      (((rd_data ^ cr0_o) & ~mask0) == '0) && (((rd_data ^ shad0) & mask0) == '0));

  assert_guest_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_sel == 2'b00) |=>
      (exit_valid || cr0_o == $past(req_wdata)));

  assert_exit_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exit_valid |-> ($stable(cr0_o) && $stable(cr4_o) && $stable(cr3_o)));

  assert_exit_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exit_valid |-> ($past(req_valid && req_write) &&
                    exit_reason == $past(req_sel) &&
                    exit_qual == $past(req_wdata)));

  assert_cr3_empty_list_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_sel == 2'b10 && tcnt == '0) |=> exit_valid);

  assert_idle_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sel == 2'b11) |=>
      (!exit_valid && $stable(cr0_o) && $stable(cr4_o) && $stable(cr3_o)));

endmodule

bind crv_intercept crv_intercept_chk #(.XLEN(XLEN), .CNT_W(CNT_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_ns),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_sel     (req_sel),
  .req_wdata   (req_wdata),
  .rd_data     (rd_data),
  .mask0       (mask_cr0),
  .shad0       (shadow_cr0),
  .tcnt        (tgt_cnt),
  .cr0_o       (cr0_o),
  .cr4_o       (cr4_o),
  .cr3_o       (cr3_o),
  .exit_valid  (exit_valid),
  .exit_reason (exit_reason),
  .exit_qual   (exit_qual)
);

// File: tb/test_crv_intercept.sv
`timescale 1ns/1ps
module test_crv_intercept;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_sel;
  logic [63:0] req_wdata, rd_data;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [63:0] cfg_wdata;
  logic [63:0] cr0_o, cr4_o, cr3_o, exit_qual;
  logic        exit_valid;
  logic [1:0]  exit_reason;

  crv_intercept i_crv_intercept (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
    .rd_data(rd_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cr0_o(cr0_o), .cr4_o(cr4_o), .cr3_o(cr3_o),
    .exit_valid(exit_valid), .exit_reason(exit_reason), .exit_qual(exit_qual)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  typedef struct {
    logic        exv;
    logic [1:0]  rsn;
    logic [63:0] qual;
    logic [63:0] c0, c4, c3;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  // reference model state
  logic [63:0] m_c0 = 64'h11, m_c4 = '0, m_c3 = '0;
  logic [63:0] m_m0 = '0, m_s0 = '0, m_m4 = '0, m_s4 = '0;
  logic [63:0] m_tgt [4] = '{default: '0};
  logic [2:0]  m_cnt = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected outcome pushed to the scoreboard
  task automatic step(input logic ce, input logic [3:0] ca, input logic [63:0] cd,
                      input logic rv, input logic rw, input logic [1:0] rs,
                      input logic [63:0] wd, input string tag);
    exp_t        e;
    logic [63:0] rexp;
    bit          hit;
    @(negedge clk);
    cfg_we = ce; cfg_addr = ca; cfg_wdata = cd;
    req_valid = rv; req_write = rw; req_sel = rs; req_wdata = wd;
    e.exv = 1'b0; e.rsn = rs; e.qual = wd; e.tag = tag;
    if (rv && !rw) begin
      case (rs)
        2'b00:   rexp = (m_c0 & ~m_m0) | (m_s0 & m_m0);
        2'b01:   rexp = (m_c4 & ~m_m4) | (m_s4 & m_m4);
        2'b10:   rexp = m_c3;
        default: rexp = '0;
      endcase
      #1;
      chk(rd_data === rexp, tag, "rd_data", rd_data, rexp);
    end
    if (rv && rw) begin
      case (rs)
        2'b00: if (|((wd ^ m_s0) & m_m0)) e.exv = 1'b1; else m_c0 = wd;
        2'b01: if (|((wd ^ m_s4) & m_m4)) e.exv = 1'b1; else m_c4 = wd;
        2'b10: begin
          hit = 0;
          for (int i = 0; i < 4; i++)
            if (i < int'(m_cnt) && m_tgt[i] == wd) hit = 1;
          if (hit) m_c3 = wd; else e.exv = 1'b1;
        end
        default: ;
      endcase
    end
    if (ce) begin
      case (ca)
        4'd0: m_m0 = cd;
        4'd1: m_s0 = cd;
        4'd2: m_m4 = cd;
        4'd3: m_s4 = cd;
        4'd4: m_cnt = cd[2:0];
        4'd8, 4'd9, 4'd10, 4'd11: m_tgt[ca - 4'd8] = cd;
        default: ;
      endcase
    end
    e.c0 = m_c0; e.c4 = m_c4; e.c3 = m_c3;
    exp_q.push_back(e);
  endtask

  task automatic gwr(input logic [1:0] rs, input logic [63:0] wd, input string tag);
    step(1'b0, 4'd0, '0, 1'b1, 1'b1, rs, wd, tag);
  endtask

  task automatic grd(input logic [1:0] rs, input string tag);
    step(1'b0, 4'd0, '0, 1'b1, 1'b0, rs, '0, tag);
  endtask

  task automatic hcfg(input logic [3:0] ca, input logic [63:0] cd, input string tag);
    step(1'b1, ca, cd, 1'b0, 1'b0, 2'b00, '0, tag);
  endtask

  // monitor: compares each result one step after its clock edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t g;
      g = exp_q.pop_front();
      chk(exit_valid === g.exv, g.tag, "exit_valid", {63'd0, exit_valid}, {63'd0, g.exv});
      if (g.exv) begin
        chk(exit_reason === g.rsn, g.tag, "exit_reason", {62'd0, exit_reason}, {62'd0, g.rsn});
        chk(exit_qual === g.qual, g.tag, "exit_qual", exit_qual, g.qual);
      end
      chk(cr0_o === g.c0, g.tag, "cr0", cr0_o, g.c0);
      chk(cr4_o === g.c4, g.tag, "cr4", cr4_o, g.c4);
      chk(cr3_o === g.c3, g.tag, "cr3", cr3_o, g.c3);
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_sel = 0; req_wdata = '0;
    cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    #1;
    chk(cr0_o === 64'h11, "R1", "cr0 reset", cr0_o, 64'h11);
    chk(cr4_o === '0, "R1", "cr4 reset", cr4_o, '0);
    chk(cr3_o === '0, "R1", "cr3 reset", cr3_o, '0);
    chk(exit_valid === 1'b0, "R1", "exit reset", {63'd0, exit_valid}, '0);
    grd(2'b00, "R1");

    // R4 free write, R9 mask applied next cycle
    gwr(2'b00, 64'hA5, "R4");
    step(1'b1, 4'd0, 64'hF0, 1'b1, 1'b1, 2'b00, 64'hFF, "R9");
    gwr(2'b00, 64'h3C, "R5");
    grd(2'b00, "R2");
    hcfg(4'd1, 64'h50, "R9");
    grd(2'b00, "R2");
    // R4 compare against shadow, not live
    gwr(2'b00, 64'h57, "R4");
    hcfg(4'd1, 64'h30, "R9");
    gwr(2'b00, 64'h57, "R5");

    // R11 reserved bits on CR4
    gwr(2'b01, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
    hcfg(4'd2, 64'hFFFF_FFFF_0000_0000, "R11");
    grd(2'b01, "R11");
    gwr(2'b01, 64'h1234, "R4");
    grd(2'b01, "R2");
    gwr(2'b01, 64'h1_0000_0000, "R6");

    // R6 back-to-back exits then quiet
    gwr(2'b00, 64'h0, "R6");
    gwr(2'b01, 64'h8000_0000_0000_0000, "R6");
    grd(2'b00, "R6");

    // CR3 filter
    grd(2'b10, "R3");
    gwr(2'b10, 64'h1000, "R8");
    hcfg(4'd8, 64'h1000, "R9");
    hcfg(4'd9, 64'h2000, "R9");
    hcfg(4'd10, 64'h3000, "R9");
    hcfg(4'd11, 64'h4000, "R9");
    hcfg(4'd4, 64'h2, "R9");
    gwr(2'b10, 64'h2000, "R7");
    gwr(2'b10, 64'h3000, "R8");
    gwr(2'b10, 64'h5000, "R8");
    hcfg(4'd4, 64'h4, "R9");
    gwr(2'b10, 64'h4000, "R7");
    hcfg(4'd4, 64'h7, "R9");
    gwr(2'b10, 64'h1000, "R7");
    grd(2'b10, "R3");
    hcfg(4'd4, 64'h0, "R9");
    gwr(2'b10, 64'h2000, "R8");

    // R10 unused select
    gwr(2'b11, 64'hDEAD, "R10");
    grd(2'b11, "R10");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "scoreboard drained",
        64'(exp_q.size()), '0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule